// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Flags Register

This block is the integer arithmetic stage of a small processor datapath. Each cycle it can accept one command. A command is either an arithmetic or logic operation on two operands, or a command that sets or clears one control or carry flag. A per-command select runs the operation at full word width (16 bits) or at byte width (the low 8 bits). The unit registers the result. It also keeps a 16-bit flags word that holds six status flags and three control flags, and it brings every flag out on a port of its own.

Additions and subtractions can take in the stored carry, so the surrounding logic can build arithmetic wider than one word. Compare uses the subtract path to set the flags and discards the difference. Increment and decrement leave the carry flag alone, which lets loop counters run alongside multi-word arithmetic. The three control flags change only through their dedicated commands.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset, `flagsWord` is 0x0002, `result` is 0 and `resultValid` is 0.
- R2: A command is taken when `opValid` is 1. `opCode` selects it: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 increment, 9 decrement, 10 clear carry, 11 set carry, 12 clear direction, 13 set direction, 14 clear interrupt, 15 set interrupt. For the ten data operations, `wordMode`=1 works on 16 bits and `wordMode`=0 works on bits 7:0. In byte mode the upper operand bits are ignored and the upper result bits are 0. `result` and the flags show the outcome on the clock edge after the command. `resultValid` is 1 for exactly that cycle, and only after add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment and decrement.
- R3: The carry flag takes the carry or borrow out of the top bit of the selected width. Add with carry adds the stored carry flag. Subtract with borrow also subtracts it.
- R4: The overflow flag is set when an add, subtract or compare gives a signed overflow at the selected width.
- R5: The auxiliary flag takes the carry or borrow out of bit 3 for arithmetic operations.
- R6: The zero flag is set when the result at the selected width is 0. The sign flag equals the top bit of the selected width.
- R7: The parity flag is set when bits 7:0 of the result hold an even number of ones, at both widths.
- R8: AND, OR and XOR clear the carry, overflow and auxiliary flags and update zero, sign and parity.
- R9: Compare sets every flag exactly as subtract would. It does not assert `resultValid` and leaves `result` unchanged.
- R10: Increment and decrement add or subtract 1 and update every status flag except carry, which keeps its value.
- R11: The six flag commands set or clear only their own flag. They leave `result` unchanged and do not assert `resultValid`.
- R12: Flag positions in `flagsWord` are: carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt 9, direction 10, overflow 11. Bit 1 always reads 1 and every other unused bit reads 0. Data operations never change the trap, interrupt or direction flags. The single-flag outputs match their bits in `flagsWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Command present this cycle |
| opCode | input | 4 | Command code |
| wordMode | input | 1 | 1 selects 16-bit, 0 selects 8-bit width |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| result | output | 16 | Registered result |
| resultValid | output | 1 | Result written this cycle |
| flagsWord | output | 16 | Complete flags register |
| carryFlag | output | 1 | Carry flag |
| parityFlag | output | 1 | Parity flag |
| auxFlag | output | 1 | Auxiliary carry flag |
| zeroFlag | output | 1 | Zero flag |
| signFlag | output | 1 | Sign flag |
| overflowFlag | output | 1 | Overflow flag |
| trapFlag | output | 1 | Trap flag |
| intFlag | output | 1 | Interrupt enable flag |
| dirFlag | output | 1 | Direction flag |

## Verification
The flags register is the only state that carries from one command to the next. A wrong stored carry therefore shows up first on the next add with carry or subtract with borrow, one cycle after that command is issued, as a result that is off by one. A wrong control flag stays hidden until it is read, so the bench reads every control flag at the ports right after a run of data operations. The decode of write-back can also go wrong, letting compare or a flag command overwrite the result. That error shows at `result` on the very next cycle, and the bench looks there after each such command.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int FLAGS_W = 16;
  localparam int PAR_W   = 8;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  localparam logic [FLAGS_W-1:0] FIXED_ONES = 16'h0002;
  localparam logic [FLAGS_W-1:0] LIVE_MASK  = 16'h0FD5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_CLC = 4'd10, OP_STC = 4'd11,
    OP_CLD = 4'd12, OP_STD = 4'd13, OP_CLI = 4'd14, OP_STI = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2} logicSel_e;
  typedef enum logic [1:0] {FS_CARRY = 2'd0, FS_DIR = 2'd1, FS_INT = 2'd2} flagSel_e;

  typedef struct packed {
    logic      arithEn;
    logic      logicEn;
    logic      subtract;
    logic      useCarry;
    logic      unitB;
    logic      keepCarry;
    logic      writeBack;
    logicSel_e logicSel;
    logic      flagCmd;
    flagSel_e  flagSel;
    logic      flagVal;
  } aluCtrl_t;
endpackage

// File: rtl/alu_flags_ctrl.sv
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic     opValid,
  input  logic [3:0] opCode,
  output aluCtrl_t ctl
);
  always_comb begin
    ctl = '0;
    ctl.logicSel = LG_AND;
    ctl.flagSel  = FS_CARRY;
    if (opValid) begin
      unique case (aluOp_e'(opCode))
        OP_ADD: begin ctl.arithEn = 1'b1; ctl.writeBack = 1'b1; end
        OP_ADC: begin ctl.arithEn = 1'b1; ctl.useCarry = 1'b1; ctl.writeBack = 1'b1; end
        OP_SUB: begin ctl.arithEn = 1'b1; ctl.subtract = 1'b1; ctl.writeBack = 1'b1; end
        OP_SBB: begin
          ctl.arithEn = 1'b1; ctl.subtract = 1'b1; ctl.useCarry = 1'b1; ctl.writeBack = 1'b1;
        end
        OP_AND: begin ctl.logicEn = 1'b1; ctl.logicSel = LG_AND; ctl.writeBack = 1'b1; end
        OP_OR:  begin ctl.logicEn = 1'b1; ctl.logicSel = LG_OR;  ctl.writeBack = 1'b1; end
        OP_XOR: begin ctl.logicEn = 1'b1; ctl.logicSel = LG_XOR; ctl.writeBack = 1'b1; end
        OP_CMP: begin ctl.arithEn = 1'b1; ctl.subtract = 1'b1; end
        OP_INC: begin
          ctl.arithEn = 1'b1; ctl.unitB = 1'b1; ctl.keepCarry = 1'b1; ctl.writeBack = 1'b1;
        end
        OP_DEC: begin
          ctl.arithEn = 1'b1; ctl.subtract = 1'b1; ctl.unitB = 1'b1;
          ctl.keepCarry = 1'b1; ctl.writeBack = 1'b1;
        end
        OP_CLC: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_CARRY; ctl.flagVal = 1'b0; end
        OP_STC: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_CARRY; ctl.flagVal = 1'b1; end
        OP_CLD: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_DIR;   ctl.flagVal = 1'b0; end
        OP_STD: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_DIR;   ctl.flagVal = 1'b1; end
        OP_CLI: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_INT;   ctl.flagVal = 1'b0; end
        OP_STI: begin ctl.flagCmd = 1'b1; ctl.flagSel = FS_INT;   ctl.flagVal = 1'b1; end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/alu_flags_datapath.sv
module alu_flags_datapath
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  aluCtrl_t           ctl,
  input  logic               wordMode,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [DATA_W-1:0]  resultQ,
  output logic               validQ,
  output logic [FLAGS_W-1:0] flagsQ
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0]  widthMask, aM, bM, logicRes, arithRes, newRes, bitMix;
  logic [DATA_W:0]    sumX, cinX;
  logic               carryOut, signA, signB, signR, ovf, aux, zero, par;
  logic [FLAGS_W-1:0] flagsD;

  always_comb begin
    widthMask = wordMode ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    aM        = opA & widthMask;
    bM        = ctl.unitB ? {{(DATA_W-1){1'b0}}, 1'b1} : (opB & widthMask);
    cinX      = {{DATA_W{1'b0}}, ctl.useCarry & flagsQ[CF_BIT]};
    sumX      = ctl.subtract ? ({1'b0, aM} - {1'b0, bM} - cinX)
                             : ({1'b0, aM} + {1'b0, bM} + cinX);
    arithRes  = sumX[DATA_W-1:0] & widthMask;
    carryOut  = wordMode ? sumX[DATA_W] : sumX[HALF_W];
    bitMix    = aM ^ bM ^ sumX[DATA_W-1:0];
    aux       = bitMix[4];
    signA     = wordMode ? aM[DATA_W-1] : aM[HALF_W-1];
    signB     = wordMode ? bM[DATA_W-1] : bM[HALF_W-1];
    signR     = wordMode ? arithRes[DATA_W-1] : arithRes[HALF_W-1];
    ovf       = ctl.subtract ? ((signA != signB) && (signR != signA))
                             : ((signA == signB) && (signR != signA));

    unique case (ctl.logicSel)
      LG_OR:   logicRes = aM | bM;
      LG_XOR:  logicRes = aM ^ bM;
      default: logicRes = aM & bM;
    endcase

    newRes = ctl.logicEn ? logicRes : arithRes;
    zero   = (newRes == '0);
    par    = ~^newRes[PAR_W-1:0];
  end

  always_comb begin
    flagsD = flagsQ;
    if (ctl.arithEn || ctl.logicEn) begin
      flagsD[ZF_BIT] = zero;
      flagsD[PF_BIT] = par;
      flagsD[SF_BIT] = wordMode ? newRes[DATA_W-1] : newRes[HALF_W-1];
      flagsD[AF_BIT] = ctl.logicEn ? 1'b0 : aux;
      flagsD[OF_BIT] = ctl.logicEn ? 1'b0 : ovf;
      flagsD[CF_BIT] = ctl.logicEn ? 1'b0 : (ctl.keepCarry ? flagsQ[CF_BIT] : carryOut);
    end
    if (ctl.flagCmd) begin
      unique case (ctl.flagSel)
        FS_DIR:  flagsD[DF_BIT] = ctl.flagVal;
        FS_INT:  flagsD[IF_BIT] = ctl.flagVal;
        default: flagsD[CF_BIT] = ctl.flagVal;
      endcase
    end
    flagsD = (flagsD & LIVE_MASK) | FIXED_ONES;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      validQ  <= 1'b0;
      flagsQ  <= FIXED_ONES;
    end else begin
      validQ <= ctl.writeBack;
      flagsQ <= flagsD;
      if (ctl.writeBack) resultQ <= newRes;
    end
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic [15:0]       flagsWord,
  output logic              carryFlag,
  output logic              parityFlag,
  output logic              auxFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              overflowFlag,
  output logic              trapFlag,
  output logic              intFlag,
  output logic              dirFlag
);
  aluCtrl_t ctl;

  alu_flags_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctl     (ctl)
  );

  alu_flags_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wordMode (wordMode),
    .opA      (opA),
    .opB      (opB),
    .resultQ  (result),
    .validQ   (resultValid),
    .flagsQ   (flagsWord)
  );

  assign carryFlag    = flagsWord[CF_BIT];
  assign parityFlag   = flagsWord[PF_BIT];
  assign auxFlag      = flagsWord[AF_BIT];
  assign zeroFlag     = flagsWord[ZF_BIT];
  assign signFlag     = flagsWord[SF_BIT];
  assign overflowFlag = flagsWord[OF_BIT];
  assign trapFlag     = flagsWord[TF_BIT];
  assign intFlag      = flagsWord[IF_BIT];
  assign dirFlag      = flagsWord[DF_BIT];
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              wordMode,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic [15:0]       flagsWord,
  input logic              carryFlag,
  input logic              parityFlag,
  input logic              zeroFlag,
  input logic              signFlag,
  input logic              overflowFlag,
  input logic              trapFlag,
  input logic              intFlag,
  input logic              dirFlag
);
  localparam int HALF_W = DATA_W / 2;

  logic isLogic, isData, isStep, isCmd;
  assign isLogic = opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR);
  assign isData  = opValid && (opCode <= OP_DEC);
  assign isStep  = opValid && (opCode == OP_INC || opCode == OP_DEC);
  assign isCmd   = opValid && (opCode >= OP_CLC || opCode == OP_CMP);

  assert_reserved_bits_R12: assert property (@(posedge clk) disable iff (!rstN)
    (flagsWord & ~LIVE_MASK) == FIXED_ONES);

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    isLogic |=> (!carryFlag && !overflowFlag));

  assert_step_keeps_carry_R10: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> (carryFlag == $past(carryFlag)));

  assert_data_keeps_control_R12: assert property (@(posedge clk) disable iff (!rstN)
    isData |=> $stable({trapFlag, intFlag, dirFlag}));

  assert_no_writeback_R9: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |=> (!resultValid && $stable(result)));

  assert_set_carry_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STC) |=> carryFlag);

  assert_set_dir_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STD) |=> dirFlag);

  assert_clear_int_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CLI) |=> !intFlag);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (zeroFlag == (result == '0)));

  assert_sign_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (signFlag == ($past(wordMode) ? result[DATA_W-1] : result[HALF_W-1])));

  assert_parity_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (parityFlag == ~^result[PAR_W-1:0]));

  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !$past(wordMode)) |-> (result[DATA_W-1:HALF_W] == '0));
endmodule

bind alu_flags_unit alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opCode       (opCode),
  .wordMode     (wordMode),
  .result       (result),
  .resultValid  (resultValid),
  .flagsWord    (flagsWord),
  .carryFlag    (carryFlag),
  .parityFlag   (parityFlag),
  .zeroFlag     (zeroFlag),
  .signFlag     (signFlag),
  .overflowFlag (overflowFlag),
  .trapFlag     (trapFlag),
  .intFlag      (intFlag),
  .dirFlag      (dirFlag)
);

// File: tb/tb_alu_flags_unit.sv
`timescale 1ns/1ps
module tb_alu_flags_unit;
  localparam logic [3:0] C_ADD = 0, C_ADC = 1, C_SUB = 2, C_SBB = 3, C_AND = 4, C_OR = 5,
                         C_XOR = 6, C_CMP = 7, C_INC = 8, C_DEC = 9, C_CLC = 10, C_STC = 11,
                         C_CLD = 12, C_STD = 13, C_CLI = 14, C_STI = 15;

  logic clk = 1'b0, rstN = 1'b0, opValid = 1'b0, wordMode = 1'b0;
  logic [3:0]  opCode = '0;
  logic [15:0] opA = '0, opB = '0;
  logic [15:0] result, flagsWord;
  logic resultValid, carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, overflowFlag;
  logic trapFlag, intFlag, dirFlag;

  always #2 clk = ~clk;

  alu_flags_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .wordMode(wordMode),
    .opA(opA), .opB(opB), .result(result), .resultValid(resultValid),
    .flagsWord(flagsWord), .carryFlag(carryFlag), .parityFlag(parityFlag),
    .auxFlag(auxFlag), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .overflowFlag(overflowFlag), .trapFlag(trapFlag), .intFlag(intFlag), .dirFlag(dirFlag)
  );

  typedef struct {
    logic [15:0] res;
    logic        rv;
    logic [15:0] flg;
    string       tag;
  } expItem_t;

  expItem_t    scoreQ[$];
  int          nChecks = 0, nFails = 0;
  logic [15:0] mdlFlags = 16'h0002, mdlRes = '0;
  logic        finished = 1'b0;

  task automatic check(input string tag, input logic ok, input logic [15:0] gotR,
                       input logic gotV, input logic [15:0] gotF, input logic [15:0] expR,
                       input logic expV, input logic [15:0] expF);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got res=%h rv=%b flags=%h, expected res=%h rv=%b flags=%h",
               tag, gotR, gotV, gotF, expR, expV, expF);
    end
  endtask

  // Reference model built from the requirement text
  task automatic issue(input logic [3:0] op, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input string tag);
    logic [15:0] m, aa, bb, rr;
    logic [16:0] r;
    logic cin, cf, sa, sb, sr, wb;
    int top;
    expItem_t it;
    m  = w ? 16'hFFFF : 16'h00FF;
    top = w ? 15 : 7;
    aa = a & m;
    bb = (op == C_INC || op == C_DEC) ? 16'd1 : (b & m);
    cin = (op == C_ADC || op == C_SBB) ? mdlFlags[0] : 1'b0;
    wb = 1'b0;
    if (op <= C_DEC) begin
      if (op == C_ADD || op == C_ADC || op == C_INC)
        r = {1'b0, aa} + {1'b0, bb} + {16'd0, cin};
      else
        r = {1'b0, aa} - {1'b0, bb} - {16'd0, cin};
      if (op == C_AND) r = {1'b0, aa & bb};
      if (op == C_OR)  r = {1'b0, aa | bb};
      if (op == C_XOR) r = {1'b0, aa ^ bb};
      rr = r[15:0] & m;
      cf = w ? r[16] : r[8];
      sa = aa[top]; sb = bb[top]; sr = rr[top];
      mdlFlags[6] = (rr == 16'd0);
      mdlFlags[7] = sr;
      mdlFlags[2] = ~^rr[7:0];
      if (op >= C_AND && op <= C_XOR) begin
        mdlFlags[0] = 1'b0; mdlFlags[11] = 1'b0; mdlFlags[4] = 1'b0;
      end else begin
        mdlFlags[4] = aa[4] ^ bb[4] ^ r[4];
        if (op == C_ADD || op == C_ADC || op == C_INC)
          mdlFlags[11] = (sa == sb) && (sr != sa);
        else
          mdlFlags[11] = (sa != sb) && (sr != sa);
        if (op != C_INC && op != C_DEC) mdlFlags[0] = cf;
      end
      if (op != C_CMP) begin wb = 1'b1; mdlRes = rr; end
    end else begin
      case (op)
        C_CLC: mdlFlags[0] = 1'b0;
        C_STC: mdlFlags[0] = 1'b1;
        C_CLD: mdlFlags[10] = 1'b0;
        C_STD: mdlFlags[10] = 1'b1;
        C_CLI: mdlFlags[9] = 1'b0;
        default: mdlFlags[9] = 1'b1;
      endcase
    end
    it.res = mdlRes; it.rv = wb; it.flg = mdlFlags; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    opCode = op; wordMode = w; opA = a; opB = b; opValid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // Monitor: pops one expected item per accepted command
  always @(posedge clk) begin
    if (rstN && opValid) begin
      expItem_t e;
      #1;
      if (scoreQ.size() == 0) begin
        check("R2 queue underflow", 1'b0, result, resultValid, flagsWord, '0, 1'b0, '0);
      end else begin
        e = scoreQ.pop_front();
        check(e.tag, (result === e.res) && (resultValid === e.rv) && (flagsWord === e.flg) &&
              ({overflowFlag, dirFlag, intFlag, trapFlag, signFlag, zeroFlag, auxFlag,
                parityFlag, carryFlag} === {e.flg[11:6], e.flg[4], e.flg[2], e.flg[0]}),
              result, resultValid, flagsWord, e.res, e.rv, e.flg);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1 reset state", (flagsWord === 16'h0002) && (result === 16'h0) && (resultValid === 1'b0),
          result, resultValid, flagsWord, 16'h0, 1'b0, 16'h0002);
    rstN = 1'b1;
    @(negedge clk);

    issue(C_ADD, 1'b0, 16'hAB7F, 16'hCD01, "R4 R5 R7 byte add signed overflow, upper bits ignored");
    issue(C_ADD, 1'b1, 16'hFFFF, 16'h0001, "R3 R6 word add carry and zero");
    issue(C_ADC, 1'b1, 16'h1000, 16'h0200, "R3 add with carry uses stored carry");
    issue(C_SUB, 1'b0, 16'h0000, 16'h0001, "R3 R5 R7 byte borrow");
    issue(C_SBB, 1'b1, 16'h8000, 16'h0000, "R3 R4 word subtract with borrow overflow");
    issue(C_SUB, 1'b1, 16'h1234, 16'h1234, "R6 word equal subtract gives zero");
    issue(C_STC, 1'b0, 16'h0, 16'h0, "R11 set carry");
    issue(C_AND, 1'b1, 16'hF0F0, 16'h8F0F, "R8 logic AND clears carry");
    issue(C_OR,  1'b0, 16'hFF00, 16'h0003, "R8 R7 byte OR");
    issue(C_XOR, 1'b1, 16'h5555, 16'h5555, "R8 R6 XOR to zero");
    issue(C_CMP, 1'b1, 16'h0001, 16'h0002, "R9 compare flags, no write-back");
    issue(C_INC, 1'b1, 16'hFFFF, 16'h0000, "R10 increment wraps, carry kept");
    issue(C_DEC, 1'b0, 16'h0080, 16'h0000, "R10 R4 byte decrement overflow");
    issue(C_CLC, 1'b0, 16'h0, 16'h0, "R11 clear carry");
    issue(C_INC, 1'b0, 16'h000F, 16'h0000, "R10 R5 increment aux carry, carry stays clear");
    issue(C_STD, 1'b0, 16'h0, 16'h0, "R11 set direction");
    issue(C_STI, 1'b0, 16'h0, 16'h0, "R11 set interrupt");
    issue(C_ADD, 1'b1, 16'h7FFF, 16'h7FFF, "R12 arithmetic keeps control flags");
    issue(C_XOR, 1'b1, 16'hFFFF, 16'h0001, "R12 logic keeps control flags");
    issue(C_CMP, 1'b0, 16'h0080, 16'h0001, "R9 byte compare overflow");
    issue(C_CLD, 1'b0, 16'h0, 16'h0, "R11 clear direction");
    issue(C_CLI, 1'b0, 16'h0, 16'h0, "R11 clear interrupt");
    idle();
    repeat (2) @(negedge clk);

    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      issue(lfsr[3:0], lfsr[4], lfsr[20:5], {lfsr[11:0], lfsr[31:28]}, "R2 mixed command stream");
      if (lfsr[27]) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", scoreQ.size() == 0, 16'(scoreQ.size()), 1'b0, '0, '0, 1'b0, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule